// File: doc/BRIEF.md
# External Trigger Input Conditioner

This block prepares an asynchronous external trigger pin for use by a timer running on a kernel clock. The pin is brought into the kernel clock domain through a flop synchroniser. A polarity bit then decides whether the high level and rising edges are active or the low level and falling edges are. The active edges can be divided by 1, 2, 4 or 8 before the signal goes to a separate digital filter stage.

The filter stage drives its output back into the block. When the second external clock mode is selected, every rising edge of that filtered signal becomes a single-cycle count-enable pulse for the timer counter. The block also flags one illegal setting: the second clock mode enabled while the trigger selector points at the filtered trigger. The prescaled signal must stay at or below a quarter of the kernel clock rate; this is a limit on use, and the block does not enforce it.

Top module: `etr_cond`

## Requirements
- R1: After reset is released with all configuration inputs at 0, `scaled_o`, `cnt_en_o` and `cfg_conflict_o` are all 0.
- R2: With `psc_code_i` = 00 and `invert_i` = 0, `scaled_o` follows the level of `pin_i`. The delay is SYNC_STAGES+1 kernel clock edges.
- R3: With `invert_i` = 1, the pin is inverted before edge detection. A low level is active, and each falling edge of `pin_i` counts as an active edge.
- R4: With `psc_code_i` = 01, 10 or 11, `scaled_o` equals bit 0, bit 1 or bit 2 of the count of active edges since the last clear. This divides the active edge rate by 2, 4 or 8.
- R5: A change of `psc_code_i` or `invert_i` clears the edge count, and the clock edge that sees the change is not counted as an active edge. For a divide code, `scaled_o` is 0 from the clock edge after the change.
- R6: With `mode2_en_i` = 1, each rising edge of `filt_i` sampled at a kernel clock edge produces exactly one cycle of `cnt_en_o` = 1, starting from that edge. Falling edges of `filt_i` produce no pulse.
- R7: With `mode2_en_i` = 0, `cnt_en_o` stays 0 whatever `filt_i` does.
- R8: `mode1_en_i` does not change the count-enable behaviour. With both modes enabled, pulses still come from `filt_i`. With only `mode1_en_i` set, no pulse is produced.
- R9: `cfg_conflict_o` is 1 exactly when `mode2_en_i` = 1 and `trig_sel_i` = 111. It follows its inputs without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous trigger pin |
| invert_i | input | 1 | 1: low level and falling edge are active |
| psc_code_i | input | 2 | Edge divider: 00 /1, 01 /2, 10 /4, 11 /8 |
| mode2_en_i | input | 1 | Second external clock mode enable |
| mode1_en_i | input | 1 | First external clock mode enable |
| trig_sel_i | input | 3 | Trigger source selector of the slave controller |
| filt_i | input | 1 | Filtered trigger returned by the filter stage |
| scaled_o | output | 1 | Synchronised, polarity-corrected, prescaled trigger |
| cnt_en_o | output | 1 | One-cycle count enable per filtered rising edge |
| cfg_conflict_o | output | 1 | Mode 2 combined with trigger selector 111 |

## Verification
The bench builds the block with its default parameters: a two-flop synchroniser, a 2-bit prescale code and a 3-bit trigger selector. At these sizes every polarity and prescale code pair can be swept through 16 active edges, which wraps the 3-bit edge count twice. All 32 combinations of both mode enables and the selector can also be tried for the conflict flag. The expected divided output is taken arithmetically from the bench's own edge tally. Clearing is checked at edge counts where a count that was not cleared would give the opposite output.

// File: rtl/etr_pkg.sv
package etr_pkg;
  parameter int unsigned PSC_CODE_W = 2;
  parameter int unsigned PSC_CNT_W  = (1 << PSC_CODE_W) - 1;
  parameter int unsigned TS_W       = 3;

  typedef logic [PSC_CODE_W-1:0] psc_code_t;

  typedef struct packed {
    logic      inv;
    psc_code_t code;
  } psc_cfg_t;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_TI  = 2'd1,
    SRC_ETR = 2'd2
  } clk_src_e;

  // mode 2 wins over mode 1: counter clocks from the filtered trigger
  function automatic clk_src_e clk_src_pick(logic m1, logic m2);
    if (m2)      return SRC_ETR;
    else if (m1) return SRC_TI;
    else         return SRC_INT;
  endfunction
endpackage

// File: rtl/etr_sync.sv
module etr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/etr_psc.sv
module etr_psc
  import etr_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     lvl_i,
  input  psc_cfg_t cfg_i,
  output logic     scaled_o
);
  logic                 pol;
  logic                 pol_q;
  logic                 cfg_chg;
  logic                 act_edge;
  psc_cfg_t             cfg_q;
  logic [PSC_CNT_W-1:0] cnt_q;
  logic                 sel;

  assign pol      = lvl_i ^ cfg_i.inv;
  assign cfg_chg  = (cfg_q != cfg_i);
  // no edge is taken in the cycle a config change is absorbed
  assign act_edge = pol & ~pol_q & ~cfg_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q <= 1'b0;
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      pol_q <= pol;
      cfg_q <= cfg_i;
      if (cfg_chg)       cnt_q <= '0;
      else if (act_edge) cnt_q <= cnt_q + 1'b1;
    end
  end

  // code k taps edge count bit k-1; code 0 passes the level
  always_comb begin
    sel = pol_q;
    for (int k = 1; k <= PSC_CNT_W; k++) begin
      if (cfg_q.code == PSC_CODE_W'(k)) sel = cnt_q[k-1];
    end
  end

  assign scaled_o = sel;
endmodule

// File: rtl/etr_clk2.sv
module etr_clk2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic filt_i,
  input  logic en_i,
  output logic pulse_o
);
  logic filt_q;
  logic pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      filt_q  <= filt_i;
      pulse_q <= en_i & filt_i & ~filt_q;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/etr_cond.sv
module etr_cond
  import etr_pkg::*;
#(
  parameter int unsigned     SYNC_STAGES = 2,
  parameter logic [TS_W-1:0] TS_RESERVED = '1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  pin_i,
  input  logic                  invert_i,
  input  logic [PSC_CODE_W-1:0] psc_code_i,
  input  logic                  mode2_en_i,
  input  logic                  mode1_en_i,
  input  logic [TS_W-1:0]       trig_sel_i,
  input  logic                  filt_i,
  output logic                  scaled_o,
  output logic                  cnt_en_o,
  output logic                  cfg_conflict_o
);
  logic     pin_sync;
  psc_cfg_t psc_cfg;
  clk_src_e clk_src;

  assign psc_cfg.inv  = invert_i;
  assign psc_cfg.code = psc_code_i;
  assign clk_src      = clk_src_pick(mode1_en_i, mode2_en_i);

  etr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  etr_psc u_psc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (pin_sync),
    .cfg_i    (psc_cfg),
    .scaled_o (scaled_o)
  );

  etr_clk2 u_clk2 (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .filt_i  (filt_i),
    .en_i    (clk_src == SRC_ETR),
    .pulse_o (cnt_en_o)
  );

  // selector must not route the filtered trigger while it is the clock
  assign cfg_conflict_o = mode2_en_i & (trig_sel_i == TS_RESERVED);
endmodule

// File: rtl/etr_cond_chk.sv
module etr_cond_chk
  import etr_pkg::*;
(
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pin_i,
  input logic                  invert_i,
  input logic [PSC_CODE_W-1:0] psc_code_i,
  input logic                  mode2_en_i,
  input logic                  mode1_en_i,
  input logic [TS_W-1:0]       trig_sel_i,
  input logic                  filt_i,
  input logic                  scaled_o,
  input logic                  cnt_en_o,
  input logic                  cfg_conflict_o
);
  assert_single_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |=> !cnt_en_o);

  assert_pulse_needs_mode2_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |-> ($past(mode2_en_i) && $past(filt_i)));

  assert_conflict_needs_mode2_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_conflict_o |-> mode2_en_i);

  assert_clear_on_code_change_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psc_code_i != $past(psc_code_i) && psc_code_i != '0)
      |=> (!scaled_o || psc_code_i != $past(psc_code_i)));
endmodule

bind etr_cond etr_cond_chk u_etr_cond_chk (.*);

// File: tb/etr_cond_bench.sv
module etr_cond_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pin_i = 1'b0;
  logic       invert_i = 1'b0;
  logic [1:0] psc_code_i = 2'd0;
  logic       mode2_en_i = 1'b0;
  logic       mode1_en_i = 1'b0;
  logic [2:0] trig_sel_i = 3'd0;
  logic       filt_i = 1'b0;
  logic       scaled_o;
  logic       cnt_en_o;
  logic       cfg_conflict_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  etr_cond u_etr_cond (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pin_i          (pin_i),
    .invert_i       (invert_i),
    .psc_code_i     (psc_code_i),
    .mode2_en_i     (mode2_en_i),
    .mode1_en_i     (mode1_en_i),
    .trig_sel_i     (trig_sel_i),
    .filt_i         (filt_i),
    .scaled_o       (scaled_o),
    .cnt_en_o       (cnt_en_o),
    .cfg_conflict_o (cfg_conflict_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic negs(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // one active pulse on the pin, 4 cycles active then 4 inactive
  task automatic pin_pulse(input logic inv, input int code, input int edges);
    logic exp;
    pin_i = ~inv;
    negs(4);
    exp = (code == 0) ? 1'b1 : 1'(edges >> (code - 1));
    chk(scaled_o, exp, (code == 0) ? (inv ? "R3 bypass active" : "R2 bypass active") : "R4 divided after edge");
    pin_i = inv;
    negs(4);
    exp = (code == 0) ? 1'b0 : 1'(edges >> (code - 1));
    chk(scaled_o, exp, (code == 0) ? (inv ? "R3 bypass idle" : "R2 bypass idle") : "R4 divided idle");
  endtask

  initial begin
    negs(3);
    rst_ni = 1'b1;
    negs(2);
    chk(scaled_o, 1'b0, "R1 scaled reset");
    chk(cnt_en_o, 1'b0, "R1 cnt_en reset");
    chk(cfg_conflict_o, 1'b0, "R1 conflict reset");

    // R2 R3 R4: sweep polarity and code over 16 edges
    for (int inv = 0; inv < 2; inv++) begin
      for (int code = 0; code < 4; code++) begin
        pin_i = 1'(inv);
        negs(4);
        invert_i   = 1'(inv);
        psc_code_i = 2'(code);
        negs(4);
        chk(scaled_o, 1'b0, "R5 fresh config idle");
        for (int e = 1; e <= 16; e++) pin_pulse(1'(inv), code, e);
      end
    end

    // R5: code change mid-count; 3 edges under /2 leave bit0=bit1=1
    invert_i = 1'b0; pin_i = 1'b0; psc_code_i = 2'd0;
    negs(4);
    psc_code_i = 2'd1;
    negs(2);
    for (int e = 1; e <= 3; e++) pin_pulse(1'b0, 1, e);
    psc_code_i = 2'd2;
    negs(1);
    chk(scaled_o, 1'b0, "R5 clear on code change");
    negs(4);
    chk(scaled_o, 1'b0, "R5 stays cleared");

    // R5 R3: polarity change mid-count, pin low becomes active level
    psc_code_i = 2'd1;
    negs(2);
    pin_pulse(1'b0, 1, 1);
    chk(scaled_o, 1'b1, "R5 one edge before flip");
    invert_i = 1'b1;
    negs(1);
    chk(scaled_o, 1'b0, "R5 clear on polarity change");
    negs(6);
    chk(scaled_o, 1'b0, "R5 active level is no edge");
    pin_i = 1'b1;
    negs(4);
    pin_i = 1'b0;
    negs(4);
    chk(scaled_o, 1'b1, "R3 falling edge counted");

    // R6 R7 R8: filtered edges to count enables
    for (int m1 = 0; m1 < 2; m1++) begin
      for (int m2 = 0; m2 < 2; m2++) begin
        mode1_en_i = 1'(m1);
        mode2_en_i = 1'(m2);
        trig_sel_i = 3'd0;
        negs(2);
        for (int rep = 0; rep < 3; rep++) begin
          filt_i = 1'b1;
          negs(1);
          chk(cnt_en_o, 1'(m2), m2 ? (m1 ? "R8 pulse with both modes" : "R6 pulse on rise")
                                   : (m1 ? "R8 mode1 alone no pulse" : "R7 no pulse mode2 off"));
          negs(1);
          chk(cnt_en_o, 1'b0, "R6 pulse one cycle");
          negs(1);
          chk(cnt_en_o, 1'b0, "R6 no repeat while high");
          filt_i = 1'b0;
          negs(1);
          chk(cnt_en_o, 1'b0, "R6 no pulse on fall");
          negs(1);
        end
      end
    end

    // R9: all selector and enable combinations
    for (int m1 = 0; m1 < 2; m1++) begin
      for (int m2 = 0; m2 < 2; m2++) begin
        for (int ts = 0; ts < 8; ts++) begin
          mode1_en_i = 1'(m1);
          mode2_en_i = 1'(m2);
          trig_sel_i = 3'(ts);
          #1;
          chk(cfg_conflict_o, 1'((m2 == 1) && (ts == 7)), "R9 conflict flag");
          negs(1);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule